// File: doc/BRIEF.md
# Collatz Trajectory Sieve Engine

The engine takes a positive starting value and repeatedly applies the Collatz map to it. An even value is halved. An odd value becomes three times itself plus one. Each cycle applies one step. A trajectory that reaches 1 is reported as verified, together with the number of steps it took.

The working value is held in a register of fixed width. If a 3n+1 update would produce a result that does not fit in that width, the engine stops and reports the candidate as overflowed. A host can then recheck that candidate in software with unbounded arithmetic. The engine therefore acts as a fast sieve: it settles almost every candidate in hardware and passes on only the few whose trajectories outgrow its register.

A candidate is loaded through a valid/ready pair on the input side. The result leaves through a second valid/ready pair and carries the original starting value, a status code and the step count. The engine handles one candidate at a time.

Top module: `collatz_sieve`

## Requirements
- R1: While idle, the engine raises `in_ready`. A candidate is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from the edge after a load until the result has been accepted.
- R2: Each clock cycle in the running state applies one map step. An even value becomes value/2. An odd value becomes 3*value+1. `out_valid` first rises s+1 edges after the load edge for a candidate verified in s steps, and s+2 edges after it for a candidate that overflows after s completed steps.
- R3: When the trajectory reaches 1, the result carries status 2'd0 (verified). The step count equals the number of map applications, subject to R7.
- R4: If a 3n+1 result is 2^VAL_W or larger, the engine stops without applying that step. The result carries status 2'd1 (overflow), and the step count covers only the steps completed before that point.
- R5: A starting value of 0 gives status 2'd2 (invalid) with a step count of 0, one edge after the load.
- R6: A starting value of 1 gives status 2'd0 with a step count of 0, one edge after the load.
- R7: The step count saturates at 2^STEP_W-1. The result is still delivered once the count has saturated.
- R8: While `out_valid` is high and `out_ready` is low, `out_start`, `out_status` and `out_steps` hold steady. `out_start` equals the value that was loaded.
- R9: The edge that accepts a result (`out_valid` and `out_ready` both high) returns the engine to idle, so `in_ready` is high and `out_valid` is low after that edge. `in_ready` and `out_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Candidate offered |
| in_ready | output | 1 | Engine idle, can take a candidate |
| in_value | input | VAL_W | Starting value |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result consumer ready |
| out_start | output | VAL_W | Starting value of the reported candidate |
| out_status | output | 2 | 0 verified, 1 overflow, 2 invalid |
| out_steps | output | STEP_W | Saturating step count |

## Verification
The assertions are checked on every cycle. They cover the handshake rules: the two ready/valid sides are mutually exclusive, a result is held steady under backpressure, and accepting a result returns the engine to idle. They also check that the status agrees with the reported start value, namely that invalid goes only with zero, a start of 1 reports zero steps, and the status code 3 never appears. Only the bench sweep can show that the arithmetic is right. It covers the step counts, the exact point at which a trajectory overflows, saturation of the count and the latency of one step per cycle. For this the bench runs every start value of a narrow configuration against a model of the trajectory.

// File: rtl/collatz_sieve_pkg.sv
package collatz_sieve_pkg;

  typedef enum logic [1:0] {
    ST_VERIFIED = 2'd0,
    ST_OVERFLOW = 2'd1,
    ST_INVALID  = 2'd2
  } status_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } ctrl_s;

  // conditions from datapath to control
  typedef struct packed {
    logic inZero;
    logic inOne;
    logic nextOne;
    logic nextOvf;
  } flags_s;

endpackage

// File: rtl/collatz_sieve_dp.sv
module collatz_sieve_dp
  import collatz_sieve_pkg::*;
#(
  parameter int VAL_W  = 64,
  parameter int STEP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_s             ctrl,
  input  logic [VAL_W-1:0]  inValue,
  output flags_s            flags,
  output logic [VAL_W-1:0]  startVal,
  output logic [STEP_W-1:0] stepCnt
);
  localparam int WORK_W = VAL_W + 2;

  logic [VAL_W-1:0]  curVal;
  logic [WORK_W-1:0] curWide;
  logic [WORK_W-1:0] nextWide;

  assign curWide = {2'b00, curVal};

  always_comb begin
    if (curVal[0]) nextWide = (curWide << 1) + curWide + WORK_W'(1);
    else           nextWide = curWide >> 1;
  end

  assign flags.nextOvf = |nextWide[WORK_W-1:VAL_W];
  assign flags.nextOne = (nextWide == WORK_W'(1));
  assign flags.inZero  = (inValue == '0);
  assign flags.inOne   = (inValue == VAL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curVal   <= '0;
      startVal <= '0;
      stepCnt  <= '0;
    end else if (ctrl.load) begin
      curVal   <= inValue;
      startVal <= inValue;
      stepCnt  <= '0;
    end else if (ctrl.step && !flags.nextOvf) begin
      curVal  <= nextWide[VAL_W-1:0];
      stepCnt <= (&stepCnt) ? stepCnt : stepCnt + STEP_W'(1);
    end
  end

endmodule

// File: rtl/collatz_sieve_ctrl.sv
module collatz_sieve_ctrl
  import collatz_sieve_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  input  logic    outReady,
  input  flags_s  flags,
  output ctrl_s   ctrl,
  output logic    inReady,
  output logic    outValid,
  output status_e status
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_e;

  state_e  state;
  state_e  stateNext;
  status_e statusNext;

  always_comb begin
    stateNext  = state;
    statusNext = status;
    ctrl       = '0;
    unique case (state)
      S_IDLE: if (inValid) begin
        ctrl.load = 1'b1;
        if (flags.inZero) begin
          stateNext  = S_DONE;
          statusNext = ST_INVALID;
        end else if (flags.inOne) begin
          stateNext  = S_DONE;
          statusNext = ST_VERIFIED;
        end else begin
          stateNext = S_RUN;
        end
      end
      S_RUN: begin
        ctrl.step = 1'b1;
        if (flags.nextOvf) begin
          stateNext  = S_DONE;
          statusNext = ST_OVERFLOW;
        end else if (flags.nextOne) begin
          stateNext  = S_DONE;
          statusNext = ST_VERIFIED;
        end
      end
      S_DONE: if (outReady) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      status <= ST_VERIFIED;
    end else begin
      state  <= stateNext;
      status <= statusNext;
    end
  end

  assign inReady  = (state == S_IDLE);
  assign outValid = (state == S_DONE);

endmodule

// File: rtl/collatz_sieve.sv
module collatz_sieve
  import collatz_sieve_pkg::*;
#(
  parameter int VAL_W  = 64,
  parameter int STEP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VAL_W-1:0]  in_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VAL_W-1:0]  out_start,
  output logic [1:0]        out_status,
  output logic [STEP_W-1:0] out_steps
);
  ctrl_s   ctrl;
  flags_s  flags;
  status_e status;

  collatz_sieve_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (in_valid),
    .outReady (out_ready),
    .flags    (flags),
    .ctrl     (ctrl),
    .inReady  (in_ready),
    .outValid (out_valid),
    .status   (status)
  );

  collatz_sieve_dp #(.VAL_W(VAL_W), .STEP_W(STEP_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .inValue  (in_value),
    .flags    (flags),
    .startVal (out_start),
    .stepCnt  (out_steps)
  );

  assign out_status = status;

endmodule

// File: rtl/collatz_sieve_checker.sv
module collatz_sieve_checker #(
  parameter int VAL_W  = 64,
  parameter int STEP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [VAL_W-1:0]  in_value,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VAL_W-1:0]  out_start,
  input logic [1:0]        out_status,
  input logic [STEP_W-1:0] out_steps
);
  // R9: the two sides never handshake at once
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R9: an accepted result returns the engine to idle
  p_return_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  // R8: result held under backpressure
  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_start)
      && $stable(out_status) && $stable(out_steps)));

  // R1: a load leaves the engine busy
  p_busy_after_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R5: invalid status only for a zero start, with zero steps
  p_invalid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'd2) |-> (out_start == '0 && out_steps == '0));

  // R6: a start of 1 reports verified with no steps
  p_start_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_start == VAL_W'(1)) |-> (out_status == 2'd0 && out_steps == '0));

  // R3 / R4: only defined status codes, and a nonzero start never reports invalid
  p_status_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_status != 2'd3));
  p_no_invalid_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_start != '0) |-> (out_status != 2'd2));

endmodule

bind collatz_sieve collatz_sieve_checker #(.VAL_W(VAL_W), .STEP_W(STEP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_value   (in_value),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_start  (out_start),
  .out_status (out_status),
  .out_steps  (out_steps)
);

// File: tb/collatz_sieve_test.sv
module collatz_sieve_test;
  localparam int VAL_W  = 8;
  localparam int STEP_W = 4;
  localparam int SAT    = (1 << STEP_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [VAL_W-1:0]  in_value = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [VAL_W-1:0]  out_start;
  logic [1:0]        out_status;
  logic [STEP_W-1:0] out_steps;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  collatz_sieve #(.VAL_W(VAL_W), .STEP_W(STEP_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .out_valid(out_valid), .out_ready(out_ready),
    .out_start(out_start), .out_status(out_status), .out_steps(out_steps)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);

    for (int n = 0; n < (1 << VAL_W); n++) begin
      longint v;
      int rawSteps;
      int expStatus;
      int expSteps;
      int expLat;
      int lat;
      // model of the trajectory
      v = n;
      rawSteps = 0;
      expStatus = 0;
      if (n == 0) expStatus = 2;
      else begin
        while (v != 1) begin
          longint nx;
          nx = (v % 2 == 1) ? 3 * v + 1 : v / 2;
          if (nx >= (longint'(1) << VAL_W)) begin
            expStatus = 1;
            break;
          end
          v = nx;
          rawSteps++;
        end
      end
      expSteps = (rawSteps > SAT) ? SAT : rawSteps;
      if (n <= 1)              expLat = 1;
      else if (expStatus == 1) expLat = rawSteps + 2;
      else                     expLat = rawSteps + 1;

      in_valid = 1'b1;
      in_value = VAL_W'(n);
      @(negedge clk);
      in_valid = 1'b0;
      lat = 1;
      if (!out_valid)
        check(in_ready == 1'b0, "R1 busy after load", int'(in_ready), 0);
      while (!out_valid && lat < 400) begin
        @(negedge clk);
        lat++;
      end
      check(lat == expLat, "R2 latency", lat, expLat);
      if (n == 0)      check(int'(out_status) == 2, "R5 invalid status", int'(out_status), 2);
      else if (n == 1) check(int'(out_status) == 0, "R6 one verified", int'(out_status), 0);
      else if (expStatus == 1)
        check(int'(out_status) == 1, "R4 overflow status", int'(out_status), 1);
      else
        check(int'(out_status) == 0, "R3 verified status", int'(out_status), 0);
      if (rawSteps > SAT)
        check(int'(out_steps) == expSteps, "R7 saturated steps", int'(out_steps), expSteps);
      else if (expStatus == 1)
        check(int'(out_steps) == expSteps, "R4 steps before overflow", int'(out_steps), expSteps);
      else
        check(int'(out_steps) == expSteps, "R3 step count", int'(out_steps), expSteps);
      check(int'(out_start) == n, "R8 start value", int'(out_start), n);

      if (n % 4 == 0) begin
        repeat (2) @(negedge clk);
        check(out_valid == 1'b1, "R8 held valid", int'(out_valid), 1);
        check(int'(out_status) == expStatus, "R8 held status", int'(out_status), expStatus);
        check(int'(out_steps) == expSteps, "R8 held steps", int'(out_steps), expSteps);
      end

      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check(in_ready == 1'b1, "R9 ready after accept", int'(in_ready), 1);
      check(out_valid == 1'b0, "R9 valid cleared", int'(out_valid), 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule